// File: doc/BRIEF.md
# Counter compare output unit

This block turns a live counter value into one digital output by comparing it against a programmable compare value. A two-bit mode input picks the behaviour. In the disabled mode the output is never driven. In the two level modes the output follows a signed magnitude test. In the one-shot mode the output is a timed pulse, which starts when the count arrives at the compare value.

All inputs are sampled on the rising clock edge, and the output is a register, so it reacts one clock after the inputs that cause it. In the one-shot mode the equality test is edge-qualified. A count that stays parked on the compare value fires the pulse once. A new arrival at the compare value restarts the timer. Any change of mode discards the pulse that is running and holds the output low for one cycle. Clearing the enable input does the same.

Top module: `cmpout_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `out_q` is 0.
- R2: Mode code 0 (disabled): `out_q` stays 0 whatever the count and compare values.
- R3: Mode code 1 (at-or-above): one clock after an edge where the mode was unchanged and `en` was 1, `out_q` equals (count >= compare) as sampled at that edge.
- R4: Mode code 2 (at-or-below): under the same conditions, `out_q` equals (count <= compare).
- R5: Both magnitude tests treat the 32-bit values as two's-complement signed numbers. For example, a count of -3 is below a compare value of 2.
- R6: Mode code 3 (one-shot): at an edge where count equals compare and did not equal it at the previous edge, a pulse length L > 0 drives `out_q` high for exactly L consecutive cycles, starting at the next edge.
- R7: In mode code 3, a count that stays equal to the compare value for many cycles produces only one pulse.
- R8: A fresh equality arrival during a running pulse reloads the timer, so the output stays high for L cycles counted from the new arrival.
- R9: A pulse length of 0 produces no pulse. An arrival with length 0 also ends any pulse that is running.
- R10: At an edge where `mode` differs from its value at the previous edge, the running pulse is discarded and `out_q` is 0 for the following cycle.
- R11: At an edge where `en` is 0, the running pulse is discarded and `out_q` is 0 for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Output enable; 0 forces the output low and discards a pulse |
| mode | input | 2 | 0 disabled, 1 at-or-above, 2 at-or-below, 3 one-shot pulse |
| cnt_val | input | 32 | Live counter value, two's complement |
| cmp_val | input | 32 | Compare value, two's complement |
| pulse_len | input | 16 | Pulse length in clock cycles |
| out_q | output | 1 | Registered digital output |

## Verification
The bench goes after the edges around equality. A count parked on the compare value must fire only once, so a level-triggered design would emit a stream of pulses. A count that leaves the compare value and comes back mid-pulse must reload the timer; a design that ignored the arrival would end the pulse too early. Negative counts against positive compare values expose an unsigned comparator, because the level modes would come out inverted. Mode switches and enable drops in the middle of a pulse show whether the timer is really cleared. A length of 0 catches an off-by-one that would wrap the timer to its maximum.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;
   typedef enum logic [1:0] {
      CMP_OFF   = 2'd0,
      CMP_GE    = 2'd1,
      CMP_LE    = 2'd2,
      CMP_PULSE = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/cmpout_compare.sv
// Magnitude and equality tests between count and compare value.
module cmpout_compare #(
   parameter int W          = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [W-1:0] cnt_i,
   input  logic [W-1:0] cmp_i,
   output logic         ge_o,
   output logic         le_o,
   output logic         eq_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("cmpout_compare: W must be at least 2");
      end
      if (SIGNED_CMP) begin : g_signed
         always_comb begin
            ge_o = $signed(cnt_i) >= $signed(cmp_i);
            le_o = $signed(cnt_i) <= $signed(cmp_i);
         end
      end else begin : g_unsigned
         always_comb begin
            ge_o = cnt_i >= cmp_i;
            le_o = cnt_i <= cmp_i;
         end
      end
   endgenerate

   assign eq_o = (cnt_i == cmp_i);
endmodule

// File: rtl/cmpout_edge.sv
// Turns the equality level into a single-cycle arrival strobe.
module cmpout_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic eq_i,
   output logic arrive_o
);
   logic eq_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_prev_q <= 1'b0;
      else        eq_prev_q <= eq_i;
   end

   assign arrive_o = eq_i & ~eq_prev_q;

   AST_ARRIVE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      arrive_o |=> !arrive_o); // R7
endmodule

// File: rtl/cmpout_pulse.sv
// One-shot timer: load on fire, count down, cleared by clear.
module cmpout_pulse #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             fire_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             hi_d_o
);
   localparam logic [LEN_W-1:0] ZERO = '0;
   localparam logic [LEN_W-1:0] ONE  = {{(LEN_W-1){1'b0}}, 1'b1};

   logic [LEN_W-1:0] rem_q, rem_d;

   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("cmpout_pulse: LEN_W must be at least 1");
      end
   endgenerate

   always_comb begin
      rem_d  = ZERO;
      hi_d_o = 1'b0;
      if (clear_i) begin
         rem_d  = ZERO;
         hi_d_o = 1'b0;
      end else if (fire_i) begin
         hi_d_o = (len_i != ZERO);
         rem_d  = (len_i != ZERO) ? len_i - ONE : ZERO;
      end else if (rem_q != ZERO) begin
         hi_d_o = 1'b1;
         rem_d  = rem_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rem_q <= ZERO;
      else        rem_q <= rem_d;
   end

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> rem_q == ZERO); // R10
   AST_ZERO_LEN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && len_i == ZERO) |=> rem_q == ZERO); // R9
endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit #(
   parameter int CNT_W      = 32,
   parameter int LEN_W      = 16,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [LEN_W-1:0] pulse_len,
   output logic             out_q
);
   import cmpout_pkg::*;

   cmp_mode_e mode_s, mode_prev_q;
   logic ge, le, eq, arrive, chg, clear, fire, pulse_hi, out_d;

   assign mode_s = cmp_mode_e'(mode);

   cmpout_compare #(.W(CNT_W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .cnt_i(cnt_val), .cmp_i(cmp_val), .ge_o(ge), .le_o(le), .eq_o(eq)
   );

   cmpout_edge u_edge (
      .clk(clk), .rst_n(rst_n), .eq_i(eq), .arrive_o(arrive)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_prev_q <= CMP_OFF;
      else        mode_prev_q <= mode_s;
   end

   assign chg   = (mode_s != mode_prev_q);
   assign clear = !en || chg || (mode_s != CMP_PULSE);
   assign fire  = arrive && (mode_s == CMP_PULSE);

   cmpout_pulse #(.LEN_W(LEN_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .fire_i(fire),
      .len_i(pulse_len), .hi_d_o(pulse_hi)
   );

   always_comb begin
      out_d = 1'b0;
      if (en && !chg) begin
         case (mode_s)
            CMP_GE:    out_d = ge;
            CMP_LE:    out_d = le;
            CMP_PULSE: out_d = pulse_hi;
            default:   out_d = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= out_d;
   end

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |=> !out_q); // R2
   AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !out_q); // R11
   AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != mode_prev_q) |=> !out_q); // R10
   AST_GE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == 2'd1 && mode_prev_q == CMP_GE)
      |=> out_q == $past($signed(cnt_val) >= $signed(cmp_val))); // R3
   AST_LE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == 2'd2 && mode_prev_q == CMP_LE)
      |=> out_q == $past($signed(cnt_val) <= $signed(cmp_val))); // R4
   AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mode == 2'd3 && mode_prev_q == CMP_PULSE && arrive && pulse_len != '0)
      |=> out_q); // R6
endmodule

// File: tb/cmpout_unit_bench.sv
`timescale 1ns/1ps
module cmpout_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [31:0] cnt_val = '0, cmp_val = '0;
   logic [15:0] pulse_len = '0;
   logic out_q;

   int total = 0, bad = 0;
   bit done = 1'b0;

   // reference model state
   logic [1:0]  m_mode_prev;
   logic        m_eq_prev, m_out;
   logic [15:0] m_rem;

   always #5 clk = ~clk;

   cmpout_unit u_cmpout_unit (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .cnt_val(cnt_val),
      .cmp_val(cmp_val), .pulse_len(pulse_len), .out_q(out_q)
   );

   task automatic check(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: out_q=%0b expected=%0b at %0t", req, got, exp, $time);
      end
   endtask

   function automatic string tag_of(input logic [1:0] md);
      case (md)
         2'd0: return "R2";
         2'd1: return "R3";
         2'd2: return "R4";
         default: return "R6";
      endcase
   endfunction

   // Advance the model by one edge using the inputs held at that edge.
   task automatic model_edge();
      logic eq, arr, chg;
      eq  = (cnt_val == cmp_val);
      arr = eq && !m_eq_prev;
      chg = (mode != m_mode_prev);
      if (!en || chg) begin
         m_out = 1'b0; m_rem = '0;
      end else begin
         case (mode)
            2'd1: begin m_out = $signed(cnt_val) >= $signed(cmp_val); m_rem = '0; end
            2'd2: begin m_out = $signed(cnt_val) <= $signed(cmp_val); m_rem = '0; end
            2'd3: begin
               if (arr) begin
                  m_out = (pulse_len != 0);
                  m_rem = (pulse_len != 0) ? pulse_len - 16'd1 : 16'd0;
               end else if (m_rem != 0) begin
                  m_out = 1'b1; m_rem = m_rem - 16'd1;
               end else m_out = 1'b0;
            end
            default: begin m_out = 1'b0; m_rem = '0; end
         endcase
      end
      m_mode_prev = mode;
      m_eq_prev   = eq;
   endtask

   task automatic step(input string req);
      @(posedge clk);
      model_edge();
      #1;
      check(req, out_q, m_out);
   endtask

   task automatic drive(input logic e, input logic [1:0] md, input int c,
                        input int p, input int len);
      en = e; mode = md; cnt_val = c; cmp_val = p; pulse_len = len[15:0];
   endtask

   initial begin : watchdog
      #2_000_000ns;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: expired, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int highs;
      void'($urandom(32'd1234));
      m_mode_prev = 2'd0; m_eq_prev = 1'b0; m_out = 1'b0; m_rem = '0;
      #1;
      check("R1", out_q, 1'b0);
      repeat (3) @(posedge clk);
      #1 check("R1", out_q, 1'b0);
      rst_n = 1'b1;

      // R3 / R5 at-or-above with equal and negative values
      drive(1, 2'd1, 5, 5, 0);  step("R10");
      step("R3");
      check("R3", out_q, 1'b1);
      drive(1, 2'd1, -3, 2, 0); step("R5");
      check("R5", out_q, 1'b0);
      drive(1, 2'd2, -3, 2, 0); step("R10");
      check("R10", out_q, 1'b0);
      step("R5");
      check("R5", out_q, 1'b1);
      drive(1, 2'd2, 7, -1, 0); step("R4");
      check("R4", out_q, 1'b0);

      // R2 disabled mode with count above compare
      drive(1, 2'd0, 100, 1, 0); step("R2"); step("R2");
      check("R2", out_q, 1'b0);

      // R6 / R7: one pulse of length 3, count parked on compare
      drive(1, 2'd3, 0, 10, 3); step("R10");
      cnt_val = 10;
      highs = 0;
      for (int i = 0; i < 12; i++) begin
         step("R7");
         if (out_q) highs++;
      end
      total++;
      if (highs != 3) begin
         bad++;
         $display("FAIL R6: high cycles=%0d expected=3", highs);
      end

      // R8 retrigger mid pulse
      pulse_len = 4; cnt_val = 9; step("R6");
      cnt_val = 10; step("R6");
      cnt_val = 9;  step("R6"); step("R6");
      cnt_val = 10; step("R8");
      highs = 0;
      for (int i = 0; i < 8; i++) begin
         step("R8");
         if (out_q) highs++;
      end
      total++;
      if (highs != 3) begin
         bad++;
         $display("FAIL R8: high cycles after reload=%0d expected=3", highs);
      end

      // R9 zero length, and zero length ending an active pulse
      cnt_val = 0; step("R9");
      pulse_len = 0; cnt_val = 10; step("R9");
      check("R9", out_q, 1'b0);
      pulse_len = 5; cnt_val = 0; step("R9");
      cnt_val = 10; step("R9"); check("R9", out_q, 1'b1);
      cnt_val = 0; step("R9");
      pulse_len = 0; cnt_val = 10; step("R9");
      check("R9", out_q, 1'b0);

      // R10 mode change during pulse, R11 enable drop during pulse
      pulse_len = 6; cnt_val = 0; step("R6");
      cnt_val = 10; step("R6");
      mode = 2'd1; step("R10"); check("R10", out_q, 1'b0);
      mode = 2'd3; step("R10");
      step("R10"); check("R10", out_q, 1'b0);
      cnt_val = 0; step("R6");
      cnt_val = 10; step("R6");
      en = 1'b0; step("R11"); check("R11", out_q, 1'b0);
      en = 1'b1; step("R11"); check("R11", out_q, 1'b0);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 60) == 0) mode = 2'($urandom_range(0, 3));
         en = ($urandom_range(0, 30) != 0);
         if ($urandom_range(0, 50) == 0) pulse_len = 16'($urandom_range(0, 7));
         if ($urandom_range(0, 200) == 0) cmp_val = $urandom_range(0, 8) - 4;
         case ($urandom_range(0, 5))
            0: cnt_val = cnt_val + 1;
            1: cnt_val = cnt_val - 1;
            2: cnt_val = cmp_val;
            3: cnt_val = $urandom;
            default: ;
         endcase
         step(en ? tag_of(mode) : "R11");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule